// File: doc/BRIEF.md
# Asynchronous SRAM Timing Controller

This block sits between a clocked requester and an external asynchronous static RAM. The requester places one read or write on a request/acknowledge port and holds it there. The controller then plays the matching cycle onto the memory pins: address, an active-low and an active-high chip select, output enable, a read/write strobe, per-byte lane selects, and a write-data bus with a separate drive enable. Write-data drive is split into an output and an enable so that the pad ring can build the bidirectional pin.

Every phase length comes from a minimum time given in nanoseconds, together with the clock period. Each length is ceil(t / period), and no length is shorter than one clock. Reads keep output enable low for the longer of the address-access window and the output-enable window, and they capture the bus on the last clock of that phase. Writes keep output enable high for the whole cycle, so the memory never drives against the controller. The first write after a read waits through an extra turnaround phase so that the memory's outputs have time to float.

Top module: `sram_timing_ctrl`

## Requirements
- R1: While reset is held, and after it until a request arrives, the memory pins are inactive. The active-low chip select is 1, the active-high chip select is 0, output enable and the read/write strobe are 1, both lane selects are 1, and data drive is 0. ack_o and rvalid_o are 0.
- R2: A read holds output enable low for exactly RD_CYC = max(ceil(T_ACC_NS/CLK_NS), ceil(T_OE_NS/CLK_NS)) consecutive cycles, which is 4 with the defaults. Output enable is low only while both chip selects are active.
- R3: Read data is the value on sram_dq_i at the last output-enable-low cycle. rvalid_o is high for exactly one cycle, the cycle right after that one. rdata_o holds its value until the next read.
- R4: A write holds the read/write strobe low for exactly WR_CYC = max of ceil(T_WP_NS), ceil(T_CW_NS) and ceil(T_DS_NS) over CLK_NS, which is 4 with the defaults. Output enable stays 1 for the whole write.
- R5: sram_dq_oe_o is 1 only while the read/write strobe is low, and sram_dq_o then equals the requested write data.
- R6: During a write, lane select bit i is low exactly when be_i[i] is 1. Bit 0 is the low byte, dq[7:0], and bit 1 is the high byte, dq[15:8]. A write with be_i = 0 leaves memory unchanged. Reads select every lane.
- R7: The first write after a read carries TA_CYC = ceil(T_HZ_NS/CLK_NS) extra cycles (2 with the defaults) before its setup. Its data drive starts at least TA_CYC cycles after output enable rises. Other writes carry no extra cycles.
- R8: Each request gets exactly one single-cycle ack_o. A request raised in an idle cycle is acknowledged 1 + SU_CYC + (RD_CYC or WR_CYC) clock edges later, plus TA_CYC when R7 applies. SU_CYC = ceil(T_AS_NS/CLK_NS), with a minimum of 1.
- R9: While the chip selects are active, sram_addr_o equals the requested address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request valid, held until ack_o |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | LANES*LANE_W | Write data |
| be_i | input | LANES | Lane write mask |
| ack_o | output | 1 | Single-cycle completion |
| rdata_o | output | LANES*LANE_W | Captured read data |
| rvalid_o | output | 1 | rdata_o updated this cycle |
| sram_addr_o | output | ADDR_W | Memory address |
| sram_ce1_no | output | 1 | Chip select, active low |
| sram_ce2_o | output | 1 | Chip select, active high |
| sram_oe_no | output | 1 | Output enable, active low |
| sram_we_no | output | 1 | Read/write strobe, low = write |
| sram_bl_no | output | LANES | Lane selects, active low |
| sram_dq_o | output | LANES*LANE_W | Write data to pad |
| sram_dq_oe_o | output | 1 | Drive enable for sram_dq_o |
| sram_dq_i | input | LANES*LANE_W | Read data from pad |

## Verification
The turnaround phase is the hardest case to reach from the ports. It appears only when a write follows a read, and its cost shows up only as extra latency and a later data drive. The stimulus therefore mixes reads and writes at random. For every transaction it tracks whether the one before was a read, then checks the acknowledge latency and the gap between output-enable release and data drive against that history. Partial and empty lane masks are checked by reading the word back through a lane-aware memory model in the bench.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_TURN, ST_SETUP, ST_ACCESS, ST_RECOVER
  } phase_e;

  // nanoseconds to clocks, rounded up, never below one
  function automatic int unsigned ns2cyc(input int unsigned t_ns, input int unsigned clk_ns);
    int unsigned c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sram_lane_sel.sv
module sram_lane_sel #(
  parameter int unsigned LANES = 2
) (
  input  logic             active_i,
  input  logic             we_i,
  input  logic [LANES-1:0] be_i,
  output logic [LANES-1:0] bl_no
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign bl_no[i] = ~(active_i & (~we_i | be_i[i]));
  end
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o,
  output logic              valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o     <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= cap_i;
      if (cap_i) q_o <= d_i;
    end
  end
endmodule

// File: rtl/sram_timing_ctrl.sv
module sram_timing_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 19,
  parameter int unsigned LANES    = 2,
  parameter int unsigned LANE_W   = 8,
  parameter int unsigned CLK_NS   = 10,
  parameter int unsigned T_ACC_NS = 40,
  parameter int unsigned T_OE_NS  = 25,
  parameter int unsigned T_WP_NS  = 30,
  parameter int unsigned T_CW_NS  = 35,
  parameter int unsigned T_DS_NS  = 20,
  parameter int unsigned T_HZ_NS  = 20,
  parameter int unsigned T_AS_NS  = 0,
  parameter int unsigned T_WR_NS  = 0
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_i,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [LANES*LANE_W-1:0]   wdata_i,
  input  logic [LANES-1:0]          be_i,
  output logic                      ack_o,
  output logic [LANES*LANE_W-1:0]   rdata_o,
  output logic                      rvalid_o,
  output logic [ADDR_W-1:0]         sram_addr_o,
  output logic                      sram_ce1_no,
  output logic                      sram_ce2_o,
  output logic                      sram_oe_no,
  output logic                      sram_we_no,
  output logic [LANES-1:0]          sram_bl_no,
  output logic [LANES*LANE_W-1:0]   sram_dq_o,
  output logic                      sram_dq_oe_o,
  input  logic [LANES*LANE_W-1:0]   sram_dq_i
);
  localparam int unsigned DATA_W = LANES * LANE_W;
  localparam int unsigned RD_CYC = max2(ns2cyc(T_ACC_NS, CLK_NS), ns2cyc(T_OE_NS, CLK_NS));
  localparam int unsigned WR_CYC = max2(max2(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_CW_NS, CLK_NS)),
                                        ns2cyc(T_DS_NS, CLK_NS));
  localparam int unsigned TA_CYC = ns2cyc(T_HZ_NS, CLK_NS);
  localparam int unsigned SU_CYC = ns2cyc(T_AS_NS, CLK_NS);
  localparam int unsigned RC_CYC = ns2cyc(T_WR_NS, CLK_NS);
  localparam int unsigned MAX_CYC = max2(max2(RD_CYC, WR_CYC), max2(max2(TA_CYC, SU_CYC), RC_CYC));
  localparam int unsigned CNT_W  = $clog2(MAX_CYC + 1);

  phase_e              state_q, state_d;
  logic                we_q, last_rd_q, take, load, cap, done, active;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [LANES-1:0]    be_q;
  logic [CNT_W-1:0]    load_val;

  always_comb begin
    state_d  = state_q;
    take     = 1'b0;
    load     = 1'b0;
    load_val = '0;
    cap      = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        take = 1'b1;
        load = 1'b1;
        if (we_i && last_rd_q) begin
          state_d  = ST_TURN;
          load_val = CNT_W'(TA_CYC - 1);
        end else begin
          state_d  = ST_SETUP;
          load_val = CNT_W'(SU_CYC - 1);
        end
      end
      ST_TURN: if (done) begin
        state_d  = ST_SETUP;
        load     = 1'b1;
        load_val = CNT_W'(SU_CYC - 1);
      end
      ST_SETUP: if (done) begin
        state_d  = ST_ACCESS;
        load     = 1'b1;
        load_val = we_q ? CNT_W'(WR_CYC - 1) : CNT_W'(RD_CYC - 1);
      end
      ST_ACCESS: if (done) begin
        state_d  = ST_RECOVER;
        load     = 1'b1;
        load_val = CNT_W'(RC_CYC - 1);
        cap      = ~we_q;
      end
      ST_RECOVER: if (done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      we_q      <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      be_q      <= '0;
      last_rd_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (take) begin
        we_q    <= we_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        be_q    <= be_i;
      end
      if (cap)                                last_rd_q <= 1'b1;
      else if (state_q == ST_SETUP && we_q)   last_rd_q <= 1'b0;
    end
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .load_val_i(load_val), .done_o(done)
  );

  sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_i(cap), .d_i(sram_dq_i),
    .q_o(rdata_o), .valid_o(rvalid_o)
  );

  assign active = (state_q == ST_SETUP) || (state_q == ST_ACCESS);

  sram_lane_sel #(.LANES(LANES)) u_lanes (
    .active_i(active), .we_i(we_q), .be_i(be_q), .bl_no(sram_bl_no)
  );

  assign ack_o        = (state_q == ST_RECOVER) && done;
  assign sram_addr_o  = addr_q;
  assign sram_ce1_no  = ~active;
  assign sram_ce2_o   = active;
  assign sram_oe_no   = ~((state_q == ST_ACCESS) && !we_q);
  assign sram_we_no   = ~((state_q == ST_ACCESS) && we_q);
  assign sram_dq_oe_o = (state_q == ST_ACCESS) && we_q;
  assign sram_dq_o    = wdata_q;
endmodule

// File: rtl/sram_timing_ctrl_chk.sv
module sram_timing_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ack_o,
  input logic rvalid_o,
  input logic sram_ce1_no,
  input logic sram_ce2_o,
  input logic sram_oe_no,
  input logic sram_we_no,
  input logic sram_dq_oe_o
);
  // R4
  oe_off_in_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> sram_oe_no);
  // R5
  drive_only_in_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> !sram_we_no);
  // R2
  oe_needs_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_oe_no |-> (!sram_ce1_no && sram_ce2_o));
  // R8
  ack_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  // R3
  rvalid_after_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> (!$past(sram_oe_no) && sram_oe_no));
  // R7
  drive_after_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_dq_oe_o) |-> ($past(sram_oe_no) && $past(sram_oe_no, 2)));
endmodule

bind sram_timing_ctrl sram_timing_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ack_o(ack_o), .rvalid_o(rvalid_o),
  .sram_ce1_no(sram_ce1_no), .sram_ce2_o(sram_ce2_o), .sram_oe_no(sram_oe_no),
  .sram_we_no(sram_we_no), .sram_dq_oe_o(sram_dq_oe_o)
);

// File: tb/sram_timing_ctrl_bench.sv
`timescale 1ns/1ps
module sram_timing_ctrl_bench;
  localparam int AW = 19;
  localparam int DW = 16;
  localparam int CLKP = 10;

  function automatic int cyc(input int t);
    int c;
    c = (t + CLKP - 1) / CLKP;
    return (c == 0) ? 1 : c;
  endfunction

  localparam int RD = (cyc(40) > cyc(25)) ? cyc(40) : cyc(25);
  localparam int WR = 4;   // max of ceil(30/10), ceil(35/10), ceil(20/10)
  localparam int TA = 2;   // ceil(20/10)
  localparam int SU = 1;

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [1:0] be = '0;
  logic ack, rvalid, ce1_n, ce2, oe_n, we_n, dq_oe;
  logic [DW-1:0] rdata, dq_o, dq_i;
  logic [AW-1:0] s_addr;
  logic [1:0] bl_n;

  always #(CLKP/2) clk = ~clk;

  sram_timing_ctrl u_sram_timing_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .be_i(be), .ack_o(ack), .rdata_o(rdata), .rvalid_o(rvalid),
    .sram_addr_o(s_addr), .sram_ce1_no(ce1_n), .sram_ce2_o(ce2), .sram_oe_no(oe_n),
    .sram_we_no(we_n), .sram_bl_no(bl_n), .sram_dq_o(dq_o), .sram_dq_oe_o(dq_oe),
    .sram_dq_i(dq_i)
  );

  // external memory model, 16 words
  logic [DW-1:0] mem [16];
  wire sel = !ce1_n && ce2;
  assign dq_i = (sel && !oe_n) ? mem[s_addr[3:0]] : 16'hA5A5;

  function automatic logic [DW-1:0] init_word(input int i);
    return DW'(i * 16'h1111) ^ 16'h0F0F;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] = init_word(i);
    end else if (sel && !we_n) begin
      if (!bl_n[0]) mem[s_addr[3:0]][7:0]  = dq_o[7:0];
      if (!bl_n[1]) mem[s_addr[3:0]][15:8] = dq_o[15:8];
    end
  end

  int n_chk = 0, n_fail = 0, m_chk = 0, m_fail = 0;

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic mchk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    m_chk++;
    if (!ok) begin
      m_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // cycle monitor
  int oe_run = 0, we_run = 0, hz = 100;
  logic ack_p = 0, dq_oe_p = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (ack && ack_p) mchk(0, "R8 ack held two cycles", 2, 1);
      if (!oe_n) oe_run++;
      else if (oe_run != 0) begin
        mchk(oe_run == RD, "R2 oe low length", oe_run, RD);
        oe_run = 0;
      end
      if (!we_n) we_run++;
      else if (we_run != 0) begin
        mchk(we_run == WR, "R4 we low length", we_run, WR);
        we_run = 0;
      end
      if (!we_n && !oe_n) mchk(0, "R4 oe low during write", 0, 1);
      if (!oe_n && !sel) mchk(0, "R2 oe without select", 0, 1);
      if (dq_oe && we_n) mchk(0, "R5 drive outside strobe", 1, 0);
      if (dq_oe && dq_o != wdata) mchk(0, "R5 write data", dq_o, wdata);
      if (sel && s_addr != addr) mchk(0, "R9 address", s_addr, addr);
      if (sel && we && bl_n != ~be) mchk(0, "R6 write lanes", bl_n, ~be);
      if (sel && !we && bl_n != 2'b00) mchk(0, "R6 read lanes", bl_n, 0);
      if (dq_oe && !dq_oe_p) mchk(hz >= TA, "R7 drive after float", hz, TA);
      if (!oe_n) hz = 0; else if (hz < 100) hz++;
      ack_p = ack;
      dq_oe_p = dq_oe;
    end
  end

  logic [DW-1:0] exp_mem [16];
  bit last_rd = 0;

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] o, input logic [DW-1:0] n,
                                          input logic [1:0] m);
    return {m[1] ? n[15:8] : o[15:8], m[0] ? n[7:0] : o[7:0]};
  endfunction

  task automatic txn(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input logic [1:0] m, input string tag);
    int lat, exp_lat;
    logic [DW-1:0] e;
    e = exp_mem[a[3:0]];
    exp_lat = 1 + SU + (w ? WR : RD) + ((w && last_rd) ? TA : 0);
    req = 1; we = w; addr = a; wdata = d; be = m;
    lat = 0;
    do begin
      @(posedge clk); lat++;
      @(negedge clk);
    end while (!ack && lat < 50);
    if (w && last_rd) chk(lat == exp_lat, {"R7 turnaround latency ", tag}, lat, exp_lat);
    else              chk(lat == exp_lat, {"R8 latency ", tag}, lat, exp_lat);
    if (w) begin
      exp_mem[a[3:0]] = merge(e, d, m);
      chk(!rvalid, "R3 no rvalid on write", rvalid, 0);
      last_rd = 0;
    end else begin
      chk(rvalid, {"R3 rvalid ", tag}, rvalid, 1);
      chk(rdata == e, {"R3 read data ", tag}, rdata, e);
      last_rd = 1;
    end
    req = 0;
    @(negedge clk);
    chk(!rvalid && !ack, "R8 single ack, R3 single rvalid", {ack, rvalid}, 0);
    if (!w) chk(rdata == e, "R3 rdata held", rdata, e);
  endtask

  initial begin
    int unsigned dummy;
    dummy = $urandom(32'd7321);
    for (int i = 0; i < 16; i++) exp_mem[i] = init_word(i);
    #1;
    chk(ce1_n && !ce2 && oe_n && we_n && bl_n == 2'b11 && !dq_oe && !ack && !rvalid,
        "R1 pins in reset", {ce1_n, ce2, oe_n, we_n, bl_n, dq_oe}, 7'b1011110);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(ce1_n && !ce2 && oe_n && we_n && bl_n == 2'b11 && !dq_oe && !ack && !rvalid,
        "R1 pins idle after reset", {ce1_n, ce2, oe_n, we_n, bl_n, dq_oe}, 7'b1011110);

    txn(0, 19'h3, '0, 2'b00, "first read");
    txn(1, 19'h5, 16'hBEEF, 2'b11, "R7 word write after read");
    txn(1, 19'h6, 16'h1234, 2'b11, "write after write");
    txn(0, 19'h5, '0, 2'b00, "readback word");
    txn(1, 19'h5, 16'h77CC, 2'b01, "R6 low lane");
    txn(0, 19'h5, '0, 2'b00, "R6 low lane readback");
    txn(1, 19'h5, 16'h4411, 2'b10, "R6 high lane");
    txn(0, 19'h5, '0, 2'b00, "R6 high lane readback");
    txn(1, 19'h9, 16'hFFFF, 2'b00, "R6 empty mask");
    txn(0, 19'h9, '0, 2'b00, "R6 empty mask readback");
    txn(0, 19'h7FFFF, '0, 2'b00, "R9 top address");

    for (int k = 0; k < 400; k++) begin
      txn($urandom_range(0, 1), AW'($urandom), DW'($urandom), 2'($urandom), "random");
    end

    for (int i = 0; i < 16; i++) txn(0, AW'(i), '0, 2'b00, "final sweep");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + m_chk, n_fail + m_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + m_chk + 1, n_fail + m_fail + 1);
    $finish;
  end
endmodule